// File: doc/BRIEF.md
# Interrupt Pending/Active Controller

This block keeps a lifecycle for each of a set of interrupt sources: idle, waiting (pending), in service (active), or in service with a fresh request already queued (pending and active). Each source is configured as either level-sensitive or edge-pulse. Incoming request lines are first synchronized. The controller then keeps a single pending flag per source and offers the most urgent waiting source to a processor through a simple request, acknowledge and return handshake that carries a source index.

The processor acknowledges the offered source when it enters the handler. It signals return with an end-of-service pulse that names the source. Only one source may be in service at a time, so a new offer appears only once the active handler has returned.

The two kinds of source behave differently at return. A level source looks at its line at that moment to decide whether to wait again. A pulse source remembers whether an edge arrived while it was in service. Surplus requests that reach a source which is already waiting merge into the one flag.

Top module: `irq_state_ctrl`

## Requirements
- R1: After a synchronous active-high reset, no source is pending or active, `req_valid_o` is 0 and `err_o` is 0.
- R2: A source configured as pulse (`src_is_pulse` bit = 1) becomes pending on a rising edge of its synchronized line. A line that stays high produces no further request.
- R3: Several requests that reach a source while its pending flag is already set merge into one. After one acknowledge and one return, the source is idle.
- R4: An acknowledge while `req_valid_o` is 1 clears the pending flag of the offered source `req_id_o` and makes that source active on the next cycle.
- R5: A level source (`src_is_pulse` bit = 0) becomes pending while its synchronized line is high and it is not active. At its return it becomes pending if the line is high at that moment, and idle otherwise.
- R6: A pulse source that sees a rising edge while active is both pending and active. At return it stays pending, and without such an edge it becomes idle.
- R7: Among pending sources, the one with the smallest priority value wins, and ties go to the lower index. The priority of source i is `src_prio[i*PW +: PW]`.
- R8: At most one source is active. `req_valid_o` is 0 whenever any source is active.
- R9: A return naming a source that is not active changes no source state and sets `err_o`. `err_o` stays set until reset.
- R10: An acknowledge while `req_valid_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Raw request line per source |
| src_is_pulse | input | NSRC | 1 = pulse source, 0 = level source |
| src_prio | input | NSRC*PW | Priority per source, smaller is more urgent |
| req_valid_o | output | 1 | A source is offered to the processor |
| req_id_o | output | IW | Index of the offered source |
| ack_i | input | 1 | Handler entry for the offered source |
| eoi_i | input | 1 | Handler return pulse |
| eoi_id_i | input | IW | Source index named by the return |
| pend_o | output | NSRC | Pending flag per source |
| act_o | output | NSRC | Active flag per source |
| err_o | output | 1 | Sticky flag for a return to a non-active source |

## Verification
The collision that matters most is a new request from a source arriving in the same cycle as that source's acknowledge or return. An edge on the acknowledge cycle must survive as a pending flag, and a level line must be sampled exactly on the return cycle. The random phase toggles lines freely while acknowledges and returns are issued at random, so these coincidences occur many times. Every cycle is compared against a bench reference model that restates the synchronizer delay and the state rules. Directed cases then provoke an edge during service, a level held across return, and priority ties.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_PEND_ACT = 2'b11
  } src_state_e;

  // a beats b when its priority value is smaller, or equal with a lower index
  function automatic logic outranks(int unsigned pa, int unsigned ia,
                                    int unsigned pb, int unsigned ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int NSRC   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] rise
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], raw[g]};
        prev <= sh[STAGES-1];
      end
    end
    assign lvl[g]  = sh[STAGES-1];
    assign rise[g] = sh[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   is_pulse,
  input  logic                   lvl,
  input  logic                   rise,
  input  logic                   take,
  input  logic                   ret,
  output logic                   pend,
  output logic                   act,
  output irq_pkg::src_state_e    st
);
  logic evt;
  assign evt = is_pulse ? rise : (lvl & ~act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      act  <= 1'b0;
    end else if (take) begin
      act  <= 1'b1;
      pend <= is_pulse & rise;
    end else if (ret) begin
      act  <= 1'b0;
      pend <= is_pulse ? (pend | rise) : lvl;
    end else begin
      pend <= pend | evt;
    end
  end

  assign st = irq_pkg::src_state_e'({act, pend});
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 4,
  parameter int PW   = 2,
  parameter int IW   = 2
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC-1:0]    act,
  input  logic [NSRC*PW-1:0] prio,
  output logic               valid,
  output logic [IW-1:0]      id
);
  logic          found;
  logic [PW-1:0] best_p;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    id     = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!found ||
          irq_pkg::outranks(32'(prio[i*PW +: PW]), 32'(i), 32'(best_p), 32'(id)))) begin
        found  = 1'b1;
        best_p = prio[i*PW +: PW];
        id     = IW'(i);
      end
    end
    valid = found & ~|act;
  end
endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl #(
  parameter int NSRC   = 4,
  parameter int PW     = 2,
  parameter int STAGES = 2,
  localparam int IW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    irq_in,
  input  logic [NSRC-1:0]    src_is_pulse,
  input  logic [NSRC*PW-1:0] src_prio,
  output logic               req_valid_o,
  output logic [IW-1:0]      req_id_o,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic [IW-1:0]      eoi_id_i,
  output logic [NSRC-1:0]    pend_o,
  output logic [NSRC-1:0]    act_o,
  output logic               err_o
);
  logic [NSRC-1:0]                 sync_lvl;
  logic [NSRC-1:0]                 sync_rise;
  logic [NSRC-1:0]                 take_vec;
  logic [NSRC-1:0]                 ret_vec;
  logic                            bad_eoi;
  irq_pkg::src_state_e [NSRC-1:0]  src_st;

  irq_sync #(.NSRC(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .lvl(sync_lvl), .rise(sync_rise)
  );

  irq_arbiter #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
    .pend(pend_o), .act(act_o), .prio(src_prio),
    .valid(req_valid_o), .id(req_id_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    assign take_vec[g] = ack_i & req_valid_o & (req_id_o == IW'(g));
    assign ret_vec[g]  = eoi_i & (eoi_id_i == IW'(g)) & act_o[g];
    irq_src_state u_cell (
      .clk(clk), .rst(rst), .is_pulse(src_is_pulse[g]),
      .lvl(sync_lvl[g]), .rise(sync_rise[g]),
      .take(take_vec[g]), .ret(ret_vec[g]),
      .pend(pend_o[g]), .act(act_o[g]), .st(src_st[g])
    );
  end

  assign bad_eoi = eoi_i & ~|ret_vec;

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else if (bad_eoi) err_o <= 1'b1;
  end
endmodule

// File: rtl/irq_state_ctrl_chk.sv
module irq_state_ctrl_chk #(
  parameter int NSRC = 4,
  parameter int IW   = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NSRC-1:0]                src_is_pulse,
  input logic                           req_valid_o,
  input logic [IW-1:0]                  req_id_o,
  input logic                           ack_i,
  input logic                           eoi_i,
  input logic [IW-1:0]                  eoi_id_i,
  input logic [NSRC-1:0]                pend_o,
  input logic [NSRC-1:0]                act_o,
  input logic                           err_o,
  input logic [NSRC-1:0]                sync_lvl,
  input logic [NSRC-1:0]                sync_rise,
  input logic [NSRC-1:0]                ret_vec,
  input irq_pkg::src_state_e [NSRC-1:0] src_st
);
  logic eoi_miss;
  assign eoi_miss = eoi_i && (((act_o >> eoi_id_i) & NSRC'(1)) == '0);

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $countones(act_o) <= 1); // R8
  AST_NO_OFFER_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (act_o == '0)); // R8
  AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> pend_o[req_id_o]); // R7
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_valid_o) |=> act_o[$past(req_id_o)]); // R4
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !req_valid_o && act_o == '0) |=> (act_o == '0)); // R10
  AST_BAD_RETURN_FLAG: assert property (@(posedge clk) disable iff (rst)
    eoi_miss |=> err_o); // R9
  AST_BAD_RETURN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (eoi_miss && !ack_i) |=> (act_o == $past(act_o))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R9

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    AST_LEVEL_RETURN: assert property (@(posedge clk) disable iff (rst)
      (ret_vec[g] && !src_is_pulse[g]) |=> (pend_o[g] == $past(sync_lvl[g]))); // R5
    AST_PULSE_RETURN: assert property (@(posedge clk) disable iff (rst)
      (ret_vec[g] && src_is_pulse[g]) |=>
        (!act_o[g] && pend_o[g] == $past(pend_o[g] | sync_rise[g]))); // R6
    AST_DUAL_ONLY_PULSE: assert property (@(posedge clk) disable iff (rst)
      (src_st[g] == irq_pkg::ST_PEND_ACT) |-> src_is_pulse[g]); // R6
  end
endmodule

bind irq_state_ctrl irq_state_ctrl_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .src_is_pulse(src_is_pulse),
  .req_valid_o(req_valid_o), .req_id_o(req_id_o), .ack_i(ack_i),
  .eoi_i(eoi_i), .eoi_id_i(eoi_id_i), .pend_o(pend_o), .act_o(act_o),
  .err_o(err_o), .sync_lvl(sync_lvl), .sync_rise(sync_rise),
  .ret_vec(ret_vec), .src_st(src_st)
);

// File: tb/irq_state_ctrl_bench.sv
module irq_state_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int PW   = 2;
  localparam int IW   = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NSRC-1:0]    irq_in = '0;
  logic [NSRC-1:0]    src_is_pulse = 4'b0011;
  logic [NSRC*PW-1:0] src_prio = '0;
  logic               req_valid_o;
  logic [IW-1:0]      req_id_o;
  logic               ack_i = 1'b0;
  logic               eoi_i = 1'b0;
  logic [IW-1:0]      eoi_id_i = '0;
  logic [NSRC-1:0]    pend_o, act_o;
  logic               err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_ctrl #(.NSRC(NSRC), .PW(PW)) u_irq_state_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .src_is_pulse(src_is_pulse),
    .src_prio(src_prio), .req_valid_o(req_valid_o), .req_id_o(req_id_o),
    .ack_i(ack_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
    .pend_o(pend_o), .act_o(act_o), .err_o(err_o)
  );

  // ---------------- reference model ----------------
  logic [NSRC-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [NSRC-1:0] m_pend = '0, m_act = '0;
  logic            m_err = 1'b0;

  // scans from the top index down; "<=" lets a lower index take a tie
  function automatic void m_offer(input logic [NSRC-1:0] p, input logic [NSRC-1:0] a,
                                  input logic [NSRC*PW-1:0] pr,
                                  output bit v, output int id);
    int best;
    best = 1 << PW;
    v = 0;
    id = 0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (p[i] && int'(pr[i*PW +: PW]) <= best) begin
        best = int'(pr[i*PW +: PW]);
        id = i;
        v = 1;
      end
    end
    if (a != '0) v = 0;
  endfunction

  always @(posedge clk) begin
    bit v;
    int id;
    bit any_ret;
    logic [NSRC-1:0] np, na;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
      m_pend <= '0; m_act <= '0; m_err <= 1'b0;
    end else begin
      m_offer(m_pend, m_act, src_prio, v, id);
      np = m_pend;
      na = m_act;
      any_ret = 0;
      for (int i = 0; i < NSRC; i++) begin
        bit r, take, ret;
        r = m_s2[i] & ~m_prev[i];
        take = ack_i && v && id == i;
        ret = eoi_i && int'(eoi_id_i) == i && m_act[i];
        if (ret) any_ret = 1;
        if (take) begin
          na[i] = 1'b1;
          np[i] = src_is_pulse[i] & r;
        end else if (ret) begin
          na[i] = 1'b0;
          np[i] = src_is_pulse[i] ? (m_pend[i] | r) : m_s2[i];
        end else if (src_is_pulse[i]) begin
          np[i] = m_pend[i] | r;
        end else if (!m_act[i]) begin
          np[i] = m_pend[i] | m_s2[i];
        end
      end
      m_pend <= np;
      m_act <= na;
      if (eoi_i && !any_ret) m_err <= 1'b1;
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    eoi_i = 1'b1; eoi_id_i = IW'(id); step(1); eoi_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; step(1);
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      bit v; int id;
      m_offer(m_pend, m_act, src_prio, v, id);
      chk("R5/R6 model pend", int'(pend_o), int'(m_pend));
      chk("R4 model act", int'(act_o), int'(m_act));
      chk("R8 model req_valid", int'(req_valid_o), int'(v));
      if (v) chk("R7 model req_id", int'(req_id_o), id);
      chk("R9 model err", int'(err_o), int'(m_err));
    end
  end

  // ---------------- directed then random ----------------
  initial begin
    step(1);
    do_reset();
    chk("R1 pend", int'(pend_o), 0);
    chk("R1 act", int'(act_o), 0);
    chk("R1 req_valid", int'(req_valid_o), 0);
    chk("R1 err", int'(err_o), 0);

    // R2: pulse source 1, held high
    irq_in[1] = 1'b1; step(4);
    chk("R2 edge pends", int'(pend_o[1]), 1);
    chk("R7 offered id", int'(req_id_o), 1);
    do_ack();
    chk("R4 active after ack", int'(act_o[1]), 1);
    chk("R4 pend cleared", int'(pend_o[1]), 0);
    step(3);
    chk("R2 steady high no repend", int'(pend_o[1]), 0);
    do_eoi(1);
    chk("R6 idle without edge", int'({pend_o[1], act_o[1]}), 0);
    irq_in[1] = 1'b0; step(3);

    // R3: three edges on source 0 merge
    for (int k = 0; k < 3; k++) begin
      irq_in[0] = 1'b1; step(3); irq_in[0] = 1'b0; step(3);
    end
    chk("R3 pending once", int'(pend_o[0]), 1);
    do_ack(); do_eoi(0);
    chk("R3 merged requests gone", int'({pend_o[0], act_o[0]}), 0);

    // R6: edge during service
    irq_in[1] = 1'b1; step(4);
    do_ack();
    irq_in[1] = 1'b0; step(2); irq_in[1] = 1'b1; step(4);
    chk("R6 pend and act", int'({pend_o[1], act_o[1]}), 3);
    chk("R8 no offer while active", int'(req_valid_o), 0);
    do_eoi(1);
    chk("R6 pending after return", int'({pend_o[1], act_o[1]}), 2);
    chk("R6 reoffered", int'(req_valid_o), 1);
    do_ack(); do_eoi(1);
    chk("R6 idle after second service", int'({pend_o[1], act_o[1]}), 0);
    irq_in[1] = 1'b0; step(3);

    // R5: level source 2
    irq_in[2] = 1'b1; step(4);
    chk("R5 level pends", int'(pend_o[2]), 1);
    do_ack(); step(2);
    chk("R5 no pend while active", int'({pend_o[2], act_o[2]}), 1);
    do_eoi(2);
    chk("R5 line high at return", int'({pend_o[2], act_o[2]}), 2);
    do_ack();
    irq_in[2] = 1'b0; step(3);
    do_eoi(2);
    chk("R5 line low at return", int'({pend_o[2], act_o[2]}), 0);

    // R8: second source waits
    irq_in[0] = 1'b1; irq_in[1] = 1'b1; step(4);
    chk("R7 lower index first", int'(req_id_o), 0);
    do_ack();
    chk("R8 other still pending", int'(pend_o[1]), 1);
    chk("R8 offer withheld", int'(req_valid_o), 0);
    do_eoi(0);
    chk("R8 next offered", int'(req_id_o), 1);
    do_ack(); do_eoi(1);
    irq_in = '0; step(3);

    // R10: stray acknowledge
    do_ack();
    chk("R10 stray ack", int'(act_o), 0);

    // R9: bad returns
    do_eoi(3);
    chk("R9 err set", int'(err_o), 1);
    chk("R9 state untouched", int'({pend_o, act_o}), 0);
    irq_in[0] = 1'b1; step(4); do_ack();
    do_eoi(2);
    chk("R9 active kept", int'(act_o), 1);
    step(2);
    chk("R9 err sticky", int'(err_o), 1);
    do_eoi(0);
    irq_in = '0; step(3);

    // R7: priorities (src0=3, src1=2, src2=1, src3=1)
    src_prio = {2'd1, 2'd1, 2'd2, 2'd3};
    irq_in = 4'b1111; step(4);
    chk("R7 tie lower index", int'(req_id_o), 2);
    do_ack(); irq_in[2] = 1'b0; step(3); do_eoi(2);
    chk("R7 second", int'(req_id_o), 3);
    do_ack(); irq_in[3] = 1'b0; step(3); do_eoi(3);
    chk("R7 third", int'(req_id_o), 1);
    do_ack(); do_eoi(1);
    chk("R7 last", int'(req_id_o), 0);
    do_ack(); do_eoi(0);
    irq_in = '0; step(3);

    // random phase, compared every cycle against the model
    begin
      int unsigned seed;
      seed = $urandom(32'h5EED_1234);
    end
    for (int pass = 0; pass < 4; pass++) begin
      src_is_pulse = NSRC'($urandom);
      src_prio = (NSRC*PW)'($urandom);
      irq_in = '0; ack_i = 1'b0; eoi_i = 1'b0;
      do_reset();
      cmp_en = 1;
      for (int c = 0; c < 1500; c++) begin
        for (int i = 0; i < NSRC; i++)
          if ($urandom % 6 == 0) irq_in[i] = ~irq_in[i];
        ack_i = req_valid_o && ($urandom % 3 == 0);
        eoi_i = 1'b0;
        if ($urandom % 40 == 0) begin
          eoi_i = 1'b1; eoi_id_i = IW'($urandom);
        end else if (act_o != '0 && $urandom % 4 == 0) begin
          eoi_i = 1'b1;
          for (int i = 0; i < NSRC; i++) if (act_o[i]) eoi_id_i = IW'(i);
        end
        step(1);
      end
      cmp_en = 0;
      ack_i = 1'b0; eoi_i = 1'b0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule